// File: doc/BRIEF.md
# USB PHY Low-Power Entry/Exit Sequencer

This block moves a USB PHY and its controller into low-power mode and back out. On a suspend request it steps through a fixed, variant-dependent list of actions. It uses a small register-access request port toward the PHY's ULPI link. It also drives the controller command bits, a PHY retention bit, the clock enables, the regulator power mode and the digital supply request. A resume request runs the reverse list. Each step starts only after the one before it has completed, so the clocks and supplies never leave the PHY in an unsafe state.

Two static inputs select the flow. The first chooses between PHY variant A and variant B. The second says whether the PHY itself or an external power controller owns VBUS/ID sensing. Variant A needs register accesses: a latch must be flushed, the comparators may be shut off, and the PLL is stopped. Variant B with external ownership needs retention and supply handling around the clock gating instead.

Top module: `usb_lpm_seq`

## Requirements
- R1: After reset, the block holds these values: all clock enables 1, reg_hpm_o 1, irq_en_o 1, and vdd_low_o, retention_o, both command bits, in_lpm_o, busy_o, done_o and ulpi_req_o all 0.
- R2: Variant A (phy_variant_i=0) entry first does a ULPI read (we=0) of address 0x14. This flushes the clear-on-read wake latch.
- R3: Variant A entry writes data 0x01 to address 0x30 only when the PHY owns sensing (ext_pwr_ctl_i=0). It skips this write when an external controller owns sensing.
- R4: Variant A entry writes 0x08 to address 0x09 as its last bus access. After that, cmd_async_o and cmd_stop_o both rise. Variant B (phy_variant_i=1) makes no bus access at all.
- R5: Each bus access holds ulpi_req_o, the address and the data steady until ulpi_done_i is seen. No later step starts before that. busy_o stays 1 from the cycle after the request until the sequence ends.
- R6: For variant B with ext_pwr_ctl_i=1, entry raises retention_o after the command bits and before any clock enable falls. After all clocks are gated, entry drops reg_hpm_o and then raises vdd_low_o.
- R7: Entry gates the clocks in this order: interface, core, protocol engine, clock source. in_lpm_o then rises as the last action, together with a one-cycle done_o.
- R8: Exit enables the clock source first, then the interface, core and protocol-engine clocks.
- R9: For variant B with ext_pwr_ctl_i=1, exit raises reg_hpm_o and then drops vdd_low_o. Only after both does it clear retention_o.
- R10: Exit clears cmd_async_o and cmd_stop_o, then clears in_lpm_o, and only then raises irq_en_o. Entry drops irq_en_o as its first action.
- R11: A resume request while not in low power gives done_o one cycle later. It causes no bus access, no output change and no busy_o.
- R12: A suspend request while in low power is ignored. No output changes and done_o does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| suspend_req_i | input | 1 | Request to enter low power, sampled when idle |
| resume_req_i | input | 1 | Request to leave low power, sampled when idle |
| phy_variant_i | input | 1 | 0 = variant A, 1 = variant B (static) |
| ext_pwr_ctl_i | input | 1 | 1 = external power controller owns VBUS/ID sensing (static) |
| ulpi_req_o | output | 1 | Register access request, held until done |
| ulpi_we_o | output | 1 | 1 = write, 0 = read |
| ulpi_addr_o | output | 8 | Register address |
| ulpi_wdata_o | output | 8 | Write data |
| ulpi_done_i | input | 1 | Access completed |
| cmd_async_o | output | 1 | Controller asynchronous-interrupt-control bit |
| cmd_stop_o | output | 1 | Controller ULPI-stop bit |
| retention_o | output | 1 | PHY retention bit |
| clk_src_en_o | output | 1 | Clock source enable |
| clk_if_en_o | output | 1 | Interface clock enable |
| clk_core_en_o | output | 1 | Core clock enable |
| clk_pe_en_o | output | 1 | Protocol-engine clock enable |
| reg_hpm_o | output | 1 | Regulator high-power mode |
| vdd_low_o | output | 1 | Request for the suspend-level digital supply |
| irq_en_o | output | 1 | Interrupt enable |
| in_lpm_o | output | 1 | Low-power flag |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when a request completes |

## Verification
The hardest case to reach is a change of variant or ownership between a finished entry and the following exit. Slow bus completions arriving in the middle of the PHY steps are also hard to bring about. The stimulus draws the variant, the ownership and a completion latency of zero to three cycles per access at random. It runs entry and exit pairs with these values and also throws stray requests at the block while it is busy. A monitor records every output edge and every bus request in order. Each recorded list is compared with one the bench builds from the two configuration bits.

// File: rtl/usb_lpm_pkg.sv
package usb_lpm_pkg;
  typedef enum logic [4:0] {
    ST_IDLE,
    ST_E_IRQ, ST_E_LATCH, ST_E_COMP, ST_E_PLL, ST_E_CMD, ST_E_RET,
    ST_E_IF, ST_E_CORE, ST_E_PE, ST_E_SRC, ST_E_REG, ST_E_VDD, ST_E_FLAG,
    ST_X_SRC, ST_X_IF, ST_X_CORE, ST_X_PE, ST_X_REG, ST_X_VDD, ST_X_RET,
    ST_X_CMD, ST_X_FLAG, ST_X_IRQ
  } step_e;
endpackage

// File: rtl/usb_lpm_bus.sv
module usb_lpm_bus #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic          cmd_we_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  output logic          ack_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          done_i
);
  logic          req_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (req_q) begin
      if (done_i) req_q <= 1'b0;
    end else if (cmd_valid_i) begin
      req_q  <= 1'b1;
      we_q   <= cmd_we_i;
      addr_q <= cmd_addr_i;
      data_q <= cmd_data_i;
    end
  end

  assign ack_o   = req_q & done_i;
  assign req_o   = req_q;
  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = data_q;
endmodule

// File: rtl/usb_lpm_ctrl.sv
module usb_lpm_ctrl
  import usb_lpm_pkg::*;
#(
  parameter int          AW         = 8,
  parameter int          DW         = 8,
  parameter bit          HAS_PE_CLK = 1'b1,
  parameter logic [AW-1:0] LATCH_ADDR = 8'h14,
  parameter logic [AW-1:0] COMP_ADDR  = 8'h30,
  parameter logic [DW-1:0] COMP_VAL   = 8'h01,
  parameter logic [AW-1:0] PLL_ADDR   = 8'h09,
  parameter logic [DW-1:0] PLL_VAL    = 8'h08
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          suspend_req_i,
  input  logic          resume_req_i,
  input  logic          phy_variant_i,
  input  logic          ext_pwr_ctl_i,
  input  logic          ack_i,
  output logic          cmd_valid_o,
  output logic          cmd_we_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_data_o,
  output logic          cmd_async_o,
  output logic          cmd_stop_o,
  output logic          retention_o,
  output logic          clk_src_en_o,
  output logic          clk_if_en_o,
  output logic          clk_core_en_o,
  output logic          clk_pe_en_o,
  output logic          reg_hpm_o,
  output logic          vdd_low_o,
  output logic          irq_en_o,
  output logic          in_lpm_o,
  output logic          busy_o,
  output logic          done_o
);
  step_e step_q;
  logic  applies, is_bus, advance, act, last;
  logic  var_a, ext_b;
  logic  async_q, stop_q, ret_q, src_q, if_q, core_q, pe_q;
  logic  hpm_q, vlow_q, irq_q, lpm_q, done_q;

  assign var_a = ~phy_variant_i;
  assign ext_b = phy_variant_i & ext_pwr_ctl_i;

  always_comb begin
    applies    = 1'b1;
    is_bus     = 1'b0;
    cmd_we_o   = 1'b0;
    cmd_addr_o = '0;
    cmd_data_o = '0;
    unique case (step_q)
      ST_E_LATCH: begin
        applies = var_a; is_bus = 1'b1; cmd_addr_o = LATCH_ADDR;
      end
      ST_E_COMP: begin
        applies = var_a & ~ext_pwr_ctl_i; is_bus = 1'b1;
        cmd_we_o = 1'b1; cmd_addr_o = COMP_ADDR; cmd_data_o = COMP_VAL;
      end
      ST_E_PLL: begin
        applies = var_a; is_bus = 1'b1;
        cmd_we_o = 1'b1; cmd_addr_o = PLL_ADDR; cmd_data_o = PLL_VAL;
      end
      ST_E_RET, ST_E_REG, ST_E_VDD, ST_X_REG, ST_X_VDD, ST_X_RET: applies = ext_b;
      ST_E_PE, ST_X_PE: applies = HAS_PE_CLK;
      default: ;
    endcase
  end

  assign cmd_valid_o = is_bus & applies;
  assign advance     = (step_q != ST_IDLE) & (~cmd_valid_o | ack_i);
  assign act         = advance & applies & ~is_bus;
  assign last        = (step_q == ST_E_FLAG) | (step_q == ST_X_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= ST_IDLE;
      async_q <= 1'b0;
      stop_q  <= 1'b0;
      ret_q   <= 1'b0;
      src_q   <= 1'b1;
      if_q    <= 1'b1;
      core_q  <= 1'b1;
      pe_q    <= 1'b1;
      hpm_q   <= 1'b1;
      vlow_q  <= 1'b0;
      irq_q   <= 1'b1;
      lpm_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (step_q == ST_IDLE) begin
        if (resume_req_i) begin
          if (lpm_q) step_q <= ST_X_SRC;
          else       done_q <= 1'b1;
        end else if (suspend_req_i && !lpm_q) begin
          step_q <= ST_E_IRQ;
        end
      end else if (advance) begin
        step_q <= last ? ST_IDLE : step_e'(step_q + 5'd1);
        if (last) done_q <= 1'b1;
      end
      if (act) begin
        unique case (step_q)
          ST_E_IRQ:  irq_q  <= 1'b0;
          ST_E_CMD:  begin async_q <= 1'b1; stop_q <= 1'b1; end
          ST_E_RET:  ret_q  <= 1'b1;
          ST_E_IF:   if_q   <= 1'b0;
          ST_E_CORE: core_q <= 1'b0;
          ST_E_PE:   pe_q   <= 1'b0;
          ST_E_SRC:  src_q  <= 1'b0;
          ST_E_REG:  hpm_q  <= 1'b0;
          ST_E_VDD:  vlow_q <= 1'b1;
          ST_E_FLAG: lpm_q  <= 1'b1;
          ST_X_SRC:  src_q  <= 1'b1;
          ST_X_IF:   if_q   <= 1'b1;
          ST_X_CORE: core_q <= 1'b1;
          ST_X_PE:   pe_q   <= 1'b1;
          ST_X_REG:  hpm_q  <= 1'b1;
          ST_X_VDD:  vlow_q <= 1'b0;
          ST_X_RET:  ret_q  <= 1'b0;
          ST_X_CMD:  begin async_q <= 1'b0; stop_q <= 1'b0; end
          ST_X_FLAG: lpm_q  <= 1'b0;
          ST_X_IRQ:  irq_q  <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign cmd_async_o   = async_q;
  assign cmd_stop_o    = stop_q;
  assign retention_o   = ret_q;
  assign clk_src_en_o  = src_q;
  assign clk_if_en_o   = if_q;
  assign clk_core_en_o = core_q;
  assign clk_pe_en_o   = pe_q;
  assign reg_hpm_o     = hpm_q;
  assign vdd_low_o     = vlow_q;
  assign irq_en_o      = irq_q;
  assign in_lpm_o      = lpm_q;
  assign busy_o        = (step_q != ST_IDLE);
  assign done_o        = done_q;
endmodule

// File: rtl/usb_lpm_seq.sv
module usb_lpm_seq #(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter bit HAS_PE_CLK = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          suspend_req_i,
  input  logic          resume_req_i,
  input  logic          phy_variant_i,
  input  logic          ext_pwr_ctl_i,
  output logic          ulpi_req_o,
  output logic          ulpi_we_o,
  output logic [AW-1:0] ulpi_addr_o,
  output logic [DW-1:0] ulpi_wdata_o,
  input  logic          ulpi_done_i,
  output logic          cmd_async_o,
  output logic          cmd_stop_o,
  output logic          retention_o,
  output logic          clk_src_en_o,
  output logic          clk_if_en_o,
  output logic          clk_core_en_o,
  output logic          clk_pe_en_o,
  output logic          reg_hpm_o,
  output logic          vdd_low_o,
  output logic          irq_en_o,
  output logic          in_lpm_o,
  output logic          busy_o,
  output logic          done_o
);
  logic          cmd_valid, cmd_we, bus_ack;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  usb_lpm_ctrl #(.AW(AW), .DW(DW), .HAS_PE_CLK(HAS_PE_CLK)) u_ctrl (
    .clk_i, .rst_ni, .suspend_req_i, .resume_req_i, .phy_variant_i, .ext_pwr_ctl_i,
    .ack_i(bus_ack), .cmd_valid_o(cmd_valid), .cmd_we_o(cmd_we),
    .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data),
    .cmd_async_o, .cmd_stop_o, .retention_o, .clk_src_en_o, .clk_if_en_o,
    .clk_core_en_o, .clk_pe_en_o, .reg_hpm_o, .vdd_low_o, .irq_en_o,
    .in_lpm_o, .busy_o, .done_o
  );

  usb_lpm_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk_i, .rst_ni, .cmd_valid_i(cmd_valid), .cmd_we_i(cmd_we),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .ack_o(bus_ack),
    .req_o(ulpi_req_o), .we_o(ulpi_we_o), .addr_o(ulpi_addr_o),
    .wdata_o(ulpi_wdata_o), .done_i(ulpi_done_i)
  );
endmodule

// File: rtl/usb_lpm_seq_chk.sv
module usb_lpm_seq_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          suspend_req_i,
  input logic          resume_req_i,
  input logic          phy_variant_i,
  input logic          ulpi_req_o,
  input logic [AW-1:0] ulpi_addr_o,
  input logic [DW-1:0] ulpi_wdata_o,
  input logic          ulpi_done_i,
  input logic          cmd_async_o,
  input logic          cmd_stop_o,
  input logic          retention_o,
  input logic          clk_src_en_o,
  input logic          clk_if_en_o,
  input logic          clk_core_en_o,
  input logic          reg_hpm_o,
  input logic          vdd_low_o,
  input logic          irq_en_o,
  input logic          in_lpm_o,
  input logic          busy_o,
  input logic          done_o
);
  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ulpi_req_o && !ulpi_done_i |=> ulpi_req_o && $stable(ulpi_addr_o) && $stable(ulpi_wdata_o));
  a_r4_bus_only_variant_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ulpi_req_o |-> busy_o && !phy_variant_i);
  a_r6_ret_before_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(retention_o) |-> clk_if_en_o && clk_src_en_o && cmd_stop_o);
  a_r9_ret_after_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(retention_o) |-> reg_hpm_o && !vdd_low_o && clk_src_en_o);
  a_r7_src_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_src_en_o) |-> !clk_if_en_o && !clk_core_en_o);
  a_r8_src_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_if_en_o) |-> clk_src_en_o);
  a_r10_irq_after_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_en_o) |-> !in_lpm_o && !cmd_async_o && !cmd_stop_o);
  a_r7_flag_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_lpm_o) |-> cmd_async_o && !clk_src_en_o && done_o);
  a_r12_suspend_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_lpm_o && !busy_o && suspend_req_i && !resume_req_i |=> !busy_o && !done_o && in_lpm_o);
  a_r11_resume_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_lpm_o && !busy_o && resume_req_i |=> !busy_o && done_o && !ulpi_req_o);
endmodule

bind usb_lpm_seq usb_lpm_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .suspend_req_i(suspend_req_i),
  .resume_req_i(resume_req_i), .phy_variant_i(phy_variant_i),
  .ulpi_req_o(ulpi_req_o), .ulpi_addr_o(ulpi_addr_o), .ulpi_wdata_o(ulpi_wdata_o),
  .ulpi_done_i(ulpi_done_i), .cmd_async_o(cmd_async_o), .cmd_stop_o(cmd_stop_o),
  .retention_o(retention_o), .clk_src_en_o(clk_src_en_o), .clk_if_en_o(clk_if_en_o),
  .clk_core_en_o(clk_core_en_o), .reg_hpm_o(reg_hpm_o), .vdd_low_o(vdd_low_o),
  .irq_en_o(irq_en_o), .in_lpm_o(in_lpm_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/usb_lpm_seq_tb.sv
module usb_lpm_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sus = 1'b0, res = 1'b0, var_b = 1'b0, ext = 1'b0, done_in = 1'b0;
  logic ulpi_req, ulpi_we;
  logic [7:0] ulpi_addr, ulpi_wdata;
  logic c_async, c_stop, ret, src, ifc, core, pe, hpm, vlow, irq, lpm, busy, done;

  int checks = 0, errors = 0;
  int bus_viol = 0, busy_viol = 0, cycles = 0;
  int log_ev[128];
  int log_n = 0;
  int exp_ev[128];
  int exp_n = 0;
  logic [10:0] prev_o;
  logic prev_req = 1'b0;
  int dly = -1;

  always #10 clk = ~clk;

  usb_lpm_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .suspend_req_i(sus), .resume_req_i(res),
    .phy_variant_i(var_b), .ext_pwr_ctl_i(ext),
    .ulpi_req_o(ulpi_req), .ulpi_we_o(ulpi_we), .ulpi_addr_o(ulpi_addr),
    .ulpi_wdata_o(ulpi_wdata), .ulpi_done_i(done_in),
    .cmd_async_o(c_async), .cmd_stop_o(c_stop), .retention_o(ret),
    .clk_src_en_o(src), .clk_if_en_o(ifc), .clk_core_en_o(core), .clk_pe_en_o(pe),
    .reg_hpm_o(hpm), .vdd_low_o(vlow), .irq_en_o(irq), .in_lpm_o(lpm),
    .busy_o(busy), .done_o(done)
  );

  function automatic logic [10:0] outs();
    return {lpm, irq, vlow, hpm, pe, core, ifc, src, ret, c_stop, c_async};
  endfunction

  // ULPI responder with random latency; flags a request dropped before done (R5)
  always @(negedge clk) begin
    if (done_in) begin
      done_in <= 1'b0;
      dly = -1;
    end else if (ulpi_req) begin
      if (dly < 0) dly = int'($urandom_range(3, 0));
      if (dly == 0) done_in <= 1'b1;
      else dly = dly - 1;
    end
    if (prev_req && !ulpi_req && dly >= 0 && !done_in) bus_viol++;
  end

  // event monitor: bus requests and every output edge, in id order per cycle
  always @(negedge clk) begin
    logic [10:0] cur;
    if (rst_n) begin
      cur = outs();
      if (ulpi_req && !prev_req && log_n < 128) begin
        log_ev[log_n] = 32'h0100_0000 | (int'(ulpi_we) << 16) | (int'(ulpi_addr) << 8) | int'(ulpi_wdata);
        log_n++;
      end
      for (int i = 0; i < 11; i++)
        if (cur[i] != prev_o[i] && log_n < 128) begin
          log_ev[log_n] = 32'h0200_0000 | (i << 1) | int'(cur[i]);
          log_n++;
        end
      prev_o = cur;
      prev_req = ulpi_req;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic int oe(input int id, input int v);
    return 32'h0200_0000 | (id << 1) | v;
  endfunction
  function automatic int be(input int we, input int a, input int d);
    return 32'h0100_0000 | (we << 16) | (a << 8) | d;
  endfunction
  task automatic push(input int e);
    exp_ev[exp_n] = e;
    exp_n++;
  endtask

  // ids: 0 async,1 stop,2 ret,3 src,4 if,5 core,6 pe,7 hpm,8 vlow,9 irq,10 lpm
  task automatic build_entry(input bit vb, input bit ex);
    exp_n = 0;
    push(oe(9, 0));
    if (!vb) begin
      push(be(0, 8'h14, 0));
      if (!ex) push(be(1, 8'h30, 8'h01));
      push(be(1, 8'h09, 8'h08));
    end
    push(oe(0, 1)); push(oe(1, 1));
    if (vb && ex) push(oe(2, 1));
    push(oe(4, 0)); push(oe(5, 0)); push(oe(6, 0)); push(oe(3, 0));
    if (vb && ex) begin push(oe(7, 0)); push(oe(8, 1)); end
    push(oe(10, 1));
  endtask

  task automatic build_exit(input bit vb, input bit ex);
    exp_n = 0;
    push(oe(3, 1)); push(oe(4, 1)); push(oe(5, 1)); push(oe(6, 1));
    if (vb && ex) begin push(oe(7, 1)); push(oe(8, 0)); push(oe(2, 0)); end
    push(oe(0, 0)); push(oe(1, 0)); push(oe(10, 0)); push(oe(9, 1));
  endtask

  // pulse a request, wait for done; busy must stay high meanwhile (R5)
  task automatic run_req(input bit is_sus, input bit noise, output bit got_done);
    got_done = 1'b0;
    log_n = 0;
    @(negedge clk);
    if (is_sus) sus = 1'b1; else res = 1'b1;
    @(negedge clk);
    sus = 1'b0; res = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (done) begin got_done = 1'b1; break; end
      if (!busy) begin busy_viol++; break; end
      if (noise) begin sus = $urandom_range(1, 0); res = $urandom_range(1, 0); end
      @(negedge clk);
      sus = 1'b0; res = 1'b0;
    end
    @(negedge clk);
    #1;
  endtask

  task automatic cmp(input string tag);
    bit ok = (log_n == exp_n);
    int bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (log_ev[i] != exp_ev[i] && bad < 0) bad = i;
    if (bad >= 0) begin
      ok = 1'b0;
      check(ok, tag, log_ev[bad], exp_ev[bad]);
    end else begin
      check(ok, {tag, " (event count)"}, log_n, exp_n);
    end
  endtask

  task automatic pair(input bit vb, input bit ex, input bit noise);
    bit d;
    var_b = vb; ext = ex;
    build_entry(vb, ex);
    run_req(1'b1, noise, d);
    check(d, "R7 entry done pulse", int'(d), 1);
    cmp($sformatf("R2 R3 R4 R6 R7 R10 entry var=%0d ext=%0d", vb, ex));
    build_exit(vb, ex);
    run_req(1'b0, noise, d);
    check(d, "R8 exit done pulse", int'(d), 1);
    cmp($sformatf("R8 R9 R10 exit var=%0d ext=%0d", vb, ex));
  endtask

  initial begin
    bit d;
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    prev_o = outs();
    // R1 reset state
    check(outs() == 11'b01011111000, "R1 output vector after reset", int'(outs()), 11'b01011111000);
    check(!busy && !done, "R1 busy/done after reset", int'({busy, done}), 0);
    check(!ulpi_req, "R1 bus request after reset", int'(ulpi_req), 0);

    // R11 resume while awake
    var_b = 1'b0; ext = 1'b0;
    run_req(1'b0, 1'b0, d);
    check(d, "R11 resume-awake done", int'(d), 1);
    check(log_n == 0, "R11 resume-awake no activity", log_n, 0);

    // directed: all four configurations
    pair(1'b0, 1'b0, 1'b0);
    pair(1'b0, 1'b1, 1'b0);
    pair(1'b1, 1'b0, 1'b0);
    pair(1'b1, 1'b1, 1'b0);

    // R12 suspend while already in low power
    var_b = 1'b1; ext = 1'b1;
    build_entry(1'b1, 1'b1);
    run_req(1'b1, 1'b0, d);
    cmp("R6 R7 entry before R12");
    log_n = 0;
    @(negedge clk); sus = 1'b1;
    @(negedge clk); sus = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check(log_n == 0, "R12 suspend in low power: no output change", log_n, 0);
    check(lpm && !busy && !done, "R12 still in low power", int'({lpm, busy, done}), 3'b100);
    build_exit(1'b1, 1'b1);
    run_req(1'b0, 1'b0, d);
    cmp("R9 exit after R12");

    // random configurations with stray requests while busy
    for (int it = 0; it < 16; it++)
      pair(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), 1'(it % 2));

    check(bus_viol == 0, "R5 bus request dropped before done", bus_viol, 0);
    check(busy_viol == 0, "R5 busy low during sequence", busy_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule